// File: doc/BRIEF.md
# Static Memory Strobe Timing Controller

This block sits between an internal request port and one asynchronous static memory or flash device. It takes one read or write request at a time and drives the device's chip select, output enable, write enable and byte-lane pins. Every phase of the access is timed in bus clock cycles by configuration fields: a delay from chip select to output enable, a delay from chip select to write enable, a read wait for the first or only read, a shorter wait for later reads of a page burst, a write wait, and an idle turnaround between accesses. Each field adds its own offset to its count.

The configuration also sets the device data width, the chip-select polarity and the byte-lane polarity scheme. It can enable four-beat asynchronous page reads, and it can enable an extended wait in which the device holds the access by pulling a wait input low. An extended wait that lasts too long is cut short after a programmable window, and a sticky flag records it. A busy output tells the requester when a new request will be taken. Completed reads return data with a one-cycle valid pulse, and completed writes give a one-cycle done pulse.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: With `cfg_cs_high`=1 the chip-select pin is high during an access and low otherwise; with `cfg_cs_high`=0 the levels are swapped. After reset no strobe is active: `busy`=0, `mem_oe_n`=1, `mem_we_n`=1, `rd_valid`=0, `tmo_flag`=0.
- R2: On reads, `mem_oe_n` goes low `cfg_oe_dly` cycles after chip select becomes active (0 means the same cycle). It stays low until chip select drops and is never low on writes.
- R3: On writes, `mem_we_n` goes low `cfg_we_dly`+1 cycles after chip select becomes active. It stays low until chip select drops, and it is never low together with `mem_oe_n`.
- R4: A read without page mode holds chip select active for `cfg_rd_wait`+1 cycles when no extended wait occurs.
- R5: With `cfg_page_en`=1 a read becomes a burst of four beats at the four word addresses that share all bits above bit 1 of `req_addr`, starting from low bits 00 and going up by one. The first beat lasts `cfg_rd_wait`+1 cycles, and each later beat lasts `cfg_pg_wait`+1 cycles. Chip select and output enable stay active across the beats. Writes stay single accesses.
- R6: A write holds chip select active for `cfg_wr_wait`+2 cycles when no extended wait occurs, and it drives `mem_wdata` with the request's data.
- R7: With a request held high, chip select stays inactive for exactly `cfg_turn`+2 cycles between two accesses: `cfg_turn`+1 turnaround cycles plus one acceptance cycle.
- R8: Width code 0 enables byte lane 0 (8 bits), code 1 enables lanes 0-1 (16 bits), code 2 enables all four lanes (32 bits), and code 3 enables none. `rd_data` keeps only the bytes of the enabled lanes and returns zero in the others.
- R9: A lane is active during an access when its `req_be` bit is set and the width enables it. With `cfg_bl_low`=0, active lanes are driven 1 on reads and 0 on writes, other lanes take the opposite level, and all lanes rest at 0 between accesses. With `cfg_bl_low`=1, active lanes are driven 0 and all other lanes, including those between accesses, are driven 1.
- R10: With `cfg_ext_en`=1, a beat that reaches its last wait cycle while `mem_wait_n` is 0 stays in that cycle until `mem_wait_n` is 1. With `cfg_ext_en`=0, `mem_wait_n` has no effect.
- R11: An extended wait that stays held for 16×(`cfg_ext_tmo`+1) cycles aborts the access. No completion pulse is given, `tmo_flag` is set, and `tmo_flag` is cleared when the next request is accepted.
- R12: `busy` rises at the clock edge that accepts a request and falls when the turnaround ends. A single access keeps `busy` high for (access cycles)+`cfg_turn`+1 cycles. A request made while `busy` is high is ignored.
- R13: Each read beat that completes gives a one-cycle `rd_valid` with `rd_data` sampled from `mem_rdata` at the addressed word. Each completed write gives a one-cycle `wr_done`. The two never occur together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when the block is idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte lanes wanted |
| cfg_width | input | 2 | Device width code |
| cfg_cs_high | input | 1 | Chip-select polarity |
| cfg_bl_low | input | 1 | Byte-lane polarity scheme |
| cfg_page_en | input | 1 | Four-beat page reads |
| cfg_ext_en | input | 1 | Extended wait enable |
| cfg_oe_dly | input | DLY_W | Output-enable delay |
| cfg_we_dly | input | DLY_W | Write-enable delay |
| cfg_rd_wait | input | WAIT_W | First or only read wait |
| cfg_pg_wait | input | WAIT_W | Later page-beat wait |
| cfg_wr_wait | input | WAIT_W | Write wait |
| cfg_turn | input | DLY_W | Turnaround |
| cfg_ext_tmo | input | TMO_W | Extended-wait timeout |
| mem_wait_n | input | 1 | Device wait, low holds the access |
| mem_rdata | input | 32 | Device read data |
| mem_cs | output | 1 | Chip select pin |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_bls | output | 4 | Byte-lane pins |
| mem_addr | output | ADDR_W | Device word address |
| mem_wdata | output | 32 | Device write data |
| busy | output | 1 | Access or turnaround in progress |
| rd_valid | output | 1 | Read beat complete |
| rd_data | output | 32 | Read data |
| wr_done | output | 1 | Write complete |
| tmo_flag | output | 1 | Last access aborted by timeout |

## Verification
The bench builds the block with its default parameters: a 16-bit word address, four byte lanes, a four-beat page and full-size delay, wait and timeout fields. It programs the timeout field to 0, 1 and 3. This gives abort windows of 16, 32 and 64 cycles, so both the abort edge and an early release can be reached in a short run. Small wait and delay values reach the edge cases where a strobe starts in the same cycle as chip select or one cycle before the beat ends.

// File: rtl/sramc_pkg.sv
package sramc_pkg;
  localparam int LANES  = 4;
  localparam int DATA_W = 8 * LANES;

  typedef enum logic [1:0] {PH_IDLE, PH_ACCESS, PH_TURN} phase_e;

  // Lanes a device width code can carry; code 3 carries none.
  function automatic logic [LANES-1:0] width_lanes(input logic [1:0] code);
    case (code)
      2'd0:    return LANES'(4'b0001);
      2'd1:    return LANES'(4'b0011);
      2'd2:    return LANES'(4'b1111);
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/sramc_phase_fsm.sv
module sramc_phase_fsm
  import sramc_pkg::*;
#(
  parameter int DLY_W      = 4,
  parameter int WAIT_W     = 5,
  parameter int TMO_W      = 10,
  parameter int PAGE_BEATS = 4,
  parameter int BEAT_W     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              cfg_page_en,
  input  logic              cfg_ext_en,
  input  logic [DLY_W-1:0]  cfg_oe_dly,
  input  logic [DLY_W-1:0]  cfg_we_dly,
  input  logic [WAIT_W-1:0] cfg_rd_wait,
  input  logic [WAIT_W-1:0] cfg_pg_wait,
  input  logic [WAIT_W-1:0] cfg_wr_wait,
  input  logic [DLY_W-1:0]  cfg_turn,
  input  logic [TMO_W-1:0]  cfg_ext_tmo,
  input  logic              mem_wait_n,
  output logic              accept,
  output logic              beat_ok,
  output logic              beat_step,
  output logic              abort,
  output logic              in_access,
  output logic              is_write,
  output logic [BEAT_W-1:0] beat,
  output logic              oe_phase,
  output logic              we_phase,
  output logic              busy_d
);
  localparam int CNT_W = WAIT_W + 1;
  localparam int TC_W  = TMO_W + 4;
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(PAGE_BEATS - 1);

  phase_e            st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [TC_W-1:0]   tc_q, tc_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic [DLY_W-1:0]  tn_q, tn_d;
  logic              wr_q, wr_d;
  logic [CNT_W-1:0]  last_idx;
  logic              at_end, hold, fin, more, tmo_hit;

  always_comb begin
    if (wr_q)              last_idx = CNT_W'(cfg_wr_wait) + CNT_W'(1);
    else if (beat_q == '0) last_idx = CNT_W'(cfg_rd_wait);
    else                   last_idx = CNT_W'(cfg_pg_wait);
  end

  assign at_end  = (st_q == PH_ACCESS) && (cnt_q == last_idx);
  assign hold    = at_end && cfg_ext_en && !mem_wait_n;
  assign tmo_hit = hold && (tc_q == {cfg_ext_tmo, 4'hF});
  assign fin     = at_end && !hold;
  assign more    = fin && !wr_q && cfg_page_en && (beat_q != LAST_BEAT);
  assign accept  = (st_q == PH_IDLE) && req_valid;

  always_comb begin
    st_d = st_q; cnt_d = cnt_q; tc_d = tc_q; beat_d = beat_q; tn_d = tn_q; wr_d = wr_q;
    case (st_q)
      PH_IDLE: if (req_valid) begin
        st_d = PH_ACCESS; cnt_d = '0; tc_d = '0; beat_d = '0; wr_d = req_write;
      end
      PH_ACCESS: begin
        if (tmo_hit) begin
          st_d = PH_TURN; tn_d = '0;
        end else if (hold) begin
          tc_d = tc_q + TC_W'(1);
        end else if (more) begin
          beat_d = beat_q + BEAT_W'(1); cnt_d = '0; tc_d = '0;
        end else if (fin) begin
          st_d = PH_TURN; tn_d = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      default: begin
        if (tn_q == cfg_turn) st_d = PH_IDLE;
        else                  tn_d = tn_q + DLY_W'(1);
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= PH_IDLE; cnt_q <= '0; tc_q <= '0; beat_q <= '0; tn_q <= '0; wr_q <= 1'b0;
    end else begin
      st_q <= st_d; cnt_q <= cnt_d; tc_q <= tc_d; beat_q <= beat_d; tn_q <= tn_d; wr_q <= wr_d;
    end
  end

  assign beat_ok   = fin;
  assign beat_step = more;
  assign abort     = tmo_hit;
  assign in_access = (st_q == PH_ACCESS);
  assign is_write  = wr_q;
  assign beat      = beat_q;
  assign oe_phase  = in_access && !wr_q && ((beat_q != '0) || (cnt_q >= CNT_W'(cfg_oe_dly)));
  assign we_phase  = in_access && wr_q && (cnt_q >= CNT_W'(cfg_we_dly) + CNT_W'(1));
  assign busy_d    = (st_d != PH_IDLE);

  // R5: writes never advance past the first beat
  p_write_single_beat_r5: assert property (@(posedge clk) disable iff (rst)
    (in_access && wr_q) |-> (beat_q == '0));
  // R7: idle is only ever entered from turnaround
  p_idle_after_turn_r7: assert property (@(posedge clk) disable iff (rst)
    (st_q == PH_IDLE && $past(st_q) != PH_IDLE) |-> ($past(st_q) == PH_TURN));
  // R11: the hold counter never passes its abort window
  p_hold_window_r11: assert property (@(posedge clk) disable iff (rst)
    in_access |-> (tc_q <= {cfg_ext_tmo, 4'hF}));
endmodule

// File: rtl/sramc_strobe_out.sv
module sramc_strobe_out
  import sramc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_access,
  input  logic             is_write,
  input  logic             oe_phase,
  input  logic             we_phase,
  input  logic [LANES-1:0] lane_sel,
  input  logic             cfg_cs_high,
  input  logic             cfg_bl_low,
  output logic             mem_cs,
  output logic             mem_oe_n,
  output logic             mem_we_n,
  output logic [LANES-1:0] mem_bls
);
  logic act_lvl;
  assign act_lvl = !cfg_bl_low && !is_write;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_cs <= ~cfg_cs_high; mem_oe_n <= 1'b1; mem_we_n <= 1'b1;
    end else begin
      mem_cs   <= in_access ? cfg_cs_high : ~cfg_cs_high;
      mem_oe_n <= ~oe_phase;
      mem_we_n <= ~we_phase;
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)            mem_bls[i] <= cfg_bl_low;
      else if (in_access) mem_bls[i] <= lane_sel[i] ? act_lvl : ~act_lvl;
      else                mem_bls[i] <= cfg_bl_low;
    end
  end

  // R3: read and write strobes are never active together
  p_oe_we_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(!mem_oe_n && !mem_we_n));
  // R2: a strobe is only active inside chip select
  p_strobe_in_cs_r2: assert property (@(posedge clk) disable iff (rst)
    ((!mem_oe_n || !mem_we_n) && $stable(cfg_cs_high)) |-> (mem_cs == cfg_cs_high));
endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
  import sramc_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DLY_W      = 4,
  parameter int WAIT_W     = 5,
  parameter int TMO_W      = 10,
  parameter int PAGE_BEATS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  input  logic [3:0]        req_be,
  input  logic [1:0]        cfg_width,
  input  logic              cfg_cs_high,
  input  logic              cfg_bl_low,
  input  logic              cfg_page_en,
  input  logic              cfg_ext_en,
  input  logic [DLY_W-1:0]  cfg_oe_dly,
  input  logic [DLY_W-1:0]  cfg_we_dly,
  input  logic [WAIT_W-1:0] cfg_rd_wait,
  input  logic [WAIT_W-1:0] cfg_pg_wait,
  input  logic [WAIT_W-1:0] cfg_wr_wait,
  input  logic [DLY_W-1:0]  cfg_turn,
  input  logic [TMO_W-1:0]  cfg_ext_tmo,
  input  logic              mem_wait_n,
  input  logic [31:0]       mem_rdata,
  output logic              mem_cs,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [3:0]        mem_bls,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  output logic              busy,
  output logic              rd_valid,
  output logic [31:0]       rd_data,
  output logic              wr_done,
  output logic              tmo_flag
);
  localparam int BEAT_W = $clog2(PAGE_BEATS);

  logic              accept, beat_ok, beat_step, abort, in_access, is_write, oe_phase, we_phase, busy_d;
  logic [BEAT_W-1:0] beat;
  logic [LANES-1:0]  lane_q, wlanes;
  logic [DATA_W-1:0] dmask;

  sramc_phase_fsm #(
    .DLY_W(DLY_W), .WAIT_W(WAIT_W), .TMO_W(TMO_W), .PAGE_BEATS(PAGE_BEATS), .BEAT_W(BEAT_W)
  ) u_fsm (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .cfg_page_en(cfg_page_en), .cfg_ext_en(cfg_ext_en), .cfg_oe_dly(cfg_oe_dly),
    .cfg_we_dly(cfg_we_dly), .cfg_rd_wait(cfg_rd_wait), .cfg_pg_wait(cfg_pg_wait),
    .cfg_wr_wait(cfg_wr_wait), .cfg_turn(cfg_turn), .cfg_ext_tmo(cfg_ext_tmo),
    .mem_wait_n(mem_wait_n), .accept(accept), .beat_ok(beat_ok), .beat_step(beat_step),
    .abort(abort), .in_access(in_access), .is_write(is_write), .beat(beat),
    .oe_phase(oe_phase), .we_phase(we_phase), .busy_d(busy_d)
  );

  sramc_strobe_out u_pins (
    .clk(clk), .rst(rst), .in_access(in_access), .is_write(is_write),
    .oe_phase(oe_phase), .we_phase(we_phase), .lane_sel(lane_q),
    .cfg_cs_high(cfg_cs_high), .cfg_bl_low(cfg_bl_low),
    .mem_cs(mem_cs), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_bls(mem_bls)
  );

  assign wlanes = width_lanes(cfg_width);
  for (genvar i = 0; i < LANES; i++) begin : g_mask
    assign dmask[8*i +: 8] = {8{wlanes[i]}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr <= '0; mem_wdata <= '0; lane_q <= '0; busy <= 1'b0;
      rd_valid <= 1'b0; wr_done <= 1'b0; rd_data <= '0; tmo_flag <= 1'b0;
    end else begin
      busy     <= busy_d;
      rd_valid <= beat_ok && !is_write;
      wr_done  <= beat_ok && is_write;
      if (beat_ok && !is_write) rd_data <= mem_rdata & dmask;
      if (accept) begin
        mem_addr  <= (cfg_page_en && !req_write) ? {req_addr[ADDR_W-1:BEAT_W], BEAT_W'(0)} : req_addr;
        mem_wdata <= req_wdata;
        lane_q    <= req_be & wlanes;
        tmo_flag  <= 1'b0;
      end else begin
        if (beat_step) mem_addr <= {mem_addr[ADDR_W-1:BEAT_W], BEAT_W'(beat + BEAT_W'(1))};
        if (abort)     tmo_flag <= 1'b1;
      end
    end
  end

  // R13: read and write completion never coincide
  p_done_excl_r13: assert property (@(posedge clk) disable iff (rst)
    !(rd_valid && wr_done));
  // R12: an active chip select is always covered by busy
  p_cs_inside_busy_r12: assert property (@(posedge clk) disable iff (rst)
    ((mem_cs == cfg_cs_high) && $stable(cfg_cs_high)) |-> busy);
  // R11: a timeout flag appears only with no completion pulse beside it
  p_tmo_no_done_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(tmo_flag) |-> !(rd_valid || wr_done));
endmodule

// File: tb/sram_strobe_ctrl_bench.sv
module sram_strobe_ctrl_bench;
  logic clk = 1'b0, rst = 1'b1;
  always #2.5 clk = ~clk;

  logic req_valid = 0, req_write = 0;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0] req_be = 4'hF;
  logic [1:0] cfg_width = 2'd2;
  logic cfg_cs_high = 1, cfg_bl_low = 0, cfg_page_en = 0, cfg_ext_en = 0;
  logic [3:0] cfg_oe_dly = 0, cfg_we_dly = 0, cfg_turn = 0;
  logic [4:0] cfg_rd_wait = 1, cfg_pg_wait = 0, cfg_wr_wait = 0;
  logic [9:0] cfg_ext_tmo = 0;
  logic mem_wait_n = 1;
  logic [31:0] mem_rdata;
  logic mem_cs, mem_oe_n, mem_we_n, busy, rd_valid, wr_done, tmo_flag;
  logic [3:0] mem_bls;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata, rd_data;

  function automatic logic [31:0] dev_word(input logic [15:0] a);
    return {a, a ^ 16'hF00F};
  endfunction
  assign mem_rdata = dev_word(mem_addr);

  sram_strobe_ctrl u_sram_strobe_ctrl (.*);

  int n_cmp = 0, n_bad = 0;
  int cs_cnt, cs_first, oe_cnt, oe_first, we_cnt, we_first, rv_cnt, wd_cnt, busy_cnt;
  logic [3:0] bls_s;
  logic [31:0] rdq [4];

  task automatic chk(input string tag, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic bit cs_on();
    return mem_cs == cfg_cs_high;
  endfunction

  task automatic run_access(input logic wr, input logic [15:0] a, input logic [31:0] d,
                            input logic [3:0] be, input int rel_at, input bit poke);
    cs_cnt = 0; oe_cnt = 0; we_cnt = 0; rv_cnt = 0; wd_cnt = 0; busy_cnt = 0;
    cs_first = -1; oe_first = -1; we_first = -1; bls_s = 'x;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    @(negedge clk);
    req_valid = 0; req_write = 0;
    for (int idx = 0; busy && idx < 5000; idx++) begin
      if (cs_on()) begin cs_cnt++; if (cs_first < 0) begin cs_first = idx; bls_s = mem_bls; end end
      if (!mem_oe_n) begin oe_cnt++; if (oe_first < 0) oe_first = idx; end
      if (!mem_we_n) begin we_cnt++; if (we_first < 0) we_first = idx; end
      if (rd_valid) begin if (rv_cnt < 4) rdq[rv_cnt] = rd_data; rv_cnt++; end
      if (wr_done) wd_cnt++;
      if (idx == rel_at) mem_wait_n = 1;
      if (poke && idx == 2) begin req_valid = 1; req_write = 1; end
      if (poke && idx == 3) begin req_valid = 0; req_write = 0; end
      busy_cnt++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk("R1 busy after reset", busy, 0);
    chk("R1 oe_n after reset", mem_oe_n, 1);
    chk("R1 we_n after reset", mem_we_n, 1);
    chk("R1 rd_valid after reset", rd_valid, 0);
    chk("R1 tmo_flag after reset", tmo_flag, 0);
    chk("R1 cs idle level high-pol", mem_cs, 0);
  endtask

  task automatic t_read_basic();
    cfg_rd_wait = 4; cfg_oe_dly = 2; cfg_turn = 1;
    run_access(0, 16'h0123, 0, 4'hF, -1, 0);
    chk("R4 read cs length", cs_cnt, 5);
    chk("R2 oe delay", oe_first - cs_first, 2);
    chk("R2 oe length", oe_cnt, 3);
    chk("R3 no we on read", we_cnt, 0);
    chk("R12 busy length", busy_cnt, 7);
    chk("R13 one rd_valid", rv_cnt, 1);
    chk("R13 read data", rdq[0], dev_word(16'h0123));
    chk("R9 mode0 read lanes", bls_s, 4'b1111);
    cfg_rd_wait = 1; cfg_oe_dly = 0;
    run_access(0, 16'h0040, 0, 4'hF, -1, 0);
    chk("R2 oe delay zero", oe_first - cs_first, 0);
    chk("R2 oe length zero delay", oe_cnt, 2);
  endtask

  task automatic t_write();
    cfg_wr_wait = 3; cfg_we_dly = 1;
    run_access(1, 16'h0200, 32'hDEADBEEF, 4'b1010, -1, 0);
    chk("R6 write cs length", cs_cnt, 5);
    chk("R3 we delay", we_first - cs_first, 2);
    chk("R3 we length", we_cnt, 3);
    chk("R2 no oe on write", oe_cnt, 0);
    chk("R13 wr_done count", wd_cnt, 1);
    chk("R13 no rd_valid on write", rv_cnt, 0);
    chk("R6 write data", mem_wdata, 32'hDEADBEEF);
    chk("R9 mode0 write lanes", bls_s, 4'b0101);
    cfg_wr_wait = 0; cfg_we_dly = 0;
    run_access(1, 16'h0201, 32'h1, 4'hF, -1, 0);
    chk("R6 short write cs length", cs_cnt, 2);
    chk("R3 we delay zero field", we_first - cs_first, 1);
    chk("R3 we length short", we_cnt, 1);
  endtask

  task automatic t_page();
    cfg_page_en = 1; cfg_rd_wait = 3; cfg_pg_wait = 1; cfg_oe_dly = 1;
    run_access(0, 16'h0106, 0, 4'hF, -1, 0);
    chk("R5 burst cs length", cs_cnt, 10);
    chk("R5 burst oe length", oe_cnt, 9);
    chk("R5 four beats", rv_cnt, 4);
    for (int i = 0; i < 4; i++)
      chk($sformatf("R5 beat %0d data", i), rdq[i], dev_word(16'h0104 + 16'(i)));
    cfg_wr_wait = 1;
    run_access(1, 16'h0106, 32'h5, 4'hF, -1, 0);
    chk("R5 page write single", wd_cnt, 1);
    chk("R5 page write cs length", cs_cnt, 3);
    cfg_page_en = 0; cfg_rd_wait = 1; cfg_oe_dly = 0;
  endtask

  task automatic t_width();
    cfg_width = 0;
    run_access(0, 16'h0301, 0, 4'hF, -1, 0);
    chk("R8 width8 lanes", bls_s, 4'b0001);
    chk("R8 width8 data", rdq[0], dev_word(16'h0301) & 32'hFF);
    cfg_width = 1;
    run_access(0, 16'h0302, 0, 4'b1110, -1, 0);
    chk("R8 width16 lanes", bls_s, 4'b0010);
    chk("R8 width16 data", rdq[0], dev_word(16'h0302) & 32'hFFFF);
    cfg_width = 3;
    run_access(0, 16'h0303, 0, 4'hF, -1, 0);
    chk("R8 reserved lanes", bls_s, 4'b0000);
    chk("R8 reserved data", rdq[0], 0);
    cfg_width = 2;
  endtask

  task automatic t_polarity();
    cfg_cs_high = 0;
    repeat (2) @(negedge clk);
    chk("R1 cs idle level low-pol", mem_cs, 1);
    run_access(0, 16'h0010, 0, 4'hF, -1, 0);
    chk("R1 low-pol cs length", cs_cnt, 2);
    cfg_cs_high = 1; cfg_bl_low = 1;
    repeat (2) @(negedge clk);
    chk("R9 mode1 rest level", mem_bls, 4'b1111);
    run_access(0, 16'h0011, 0, 4'b0110, -1, 0);
    chk("R9 mode1 read lanes", bls_s, 4'b1001);
    run_access(1, 16'h0012, 0, 4'b0011, -1, 0);
    chk("R9 mode1 write lanes", bls_s, 4'b1100);
    cfg_bl_low = 0;
    repeat (2) @(negedge clk);
    chk("R9 mode0 rest level", mem_bls, 4'b0000);
  endtask

  task automatic t_turn();
    int ph, gap;
    cfg_turn = 3; cfg_rd_wait = 1; ph = 0; gap = 0;
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = 16'h0020;
    for (int i = 0; i < 200 && ph < 3; i++) begin
      @(negedge clk);
      if (ph == 0 && cs_on()) ph = 1;
      else if (ph == 1 && !cs_on()) begin ph = 2; gap = 1; end
      else if (ph == 2) begin
        if (cs_on()) begin ph = 3; req_valid = 0; end else gap++;
      end
    end
    req_valid = 0;
    chk("R7 back-to-back gap", gap, 5);
    while (busy) @(negedge clk);
    run_access(0, 16'h0021, 0, 4'hF, -1, 0);
    chk("R12 busy with long turn", busy_cnt, 6);
    cfg_turn = 0;
  endtask

  task automatic t_ext();
    cfg_rd_wait = 2;
    mem_wait_n = 0; cfg_ext_en = 0;
    run_access(0, 16'h0030, 0, 4'hF, -1, 0);
    chk("R10 wait ignored when off", cs_cnt, 3);
    chk("R10 completes when off", rv_cnt, 1);
    cfg_ext_en = 1; cfg_ext_tmo = 3;
    run_access(0, 16'h0031, 0, 4'hF, 10, 0);
    chk("R10 held until release", cs_cnt, 11);
    chk("R10 completes after release", rv_cnt, 1);
    chk("R10 no timeout on release", tmo_flag, 0);
    run_access(0, 16'h0032, 0, 4'hF, -1, 0);
    chk("R10 no hold with wait high", cs_cnt, 3);
  endtask

  task automatic t_timeout();
    cfg_ext_en = 1; cfg_ext_tmo = 0; cfg_rd_wait = 2; cfg_turn = 1; mem_wait_n = 0;
    run_access(0, 16'h0040, 0, 4'hF, -1, 0);
    chk("R11 abort at 16", cs_cnt, 18);
    chk("R11 no rd_valid on abort", rv_cnt, 0);
    chk("R11 flag set", tmo_flag, 1);
    chk("R12 busy on abort", busy_cnt, 20);
    cfg_ext_tmo = 1; cfg_wr_wait = 0; mem_wait_n = 0;
    run_access(1, 16'h0041, 0, 4'hF, -1, 0);
    chk("R11 abort at 32", cs_cnt, 33);
    chk("R11 no wr_done on abort", wd_cnt, 0);
    mem_wait_n = 1;
    run_access(0, 16'h0042, 0, 4'hF, -1, 0);
    chk("R11 flag cleared", tmo_flag, 0);
    chk("R11 next read completes", rv_cnt, 1);
    cfg_ext_en = 0; cfg_turn = 0;
  endtask

  task automatic t_ignore();
    cfg_rd_wait = 2;
    run_access(0, 16'h0050, 0, 4'hF, -1, 1);
    chk("R12 poked cs length", cs_cnt, 3);
    chk("R12 no write started", we_cnt, 0);
    chk("R12 no wr_done", wd_cnt, 0);
    @(negedge clk);
    chk("R12 stays idle", busy, 0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_read_basic();
    t_write();
    t_page();
    t_width();
    t_polarity();
    t_turn();
    t_ext();
    t_timeout();
    t_ignore();
    summary();
  end
endmodule